// File: doc/BRIEF.md
# Addressed Three-Wire Serial Configuration Port

This block receives configuration frames over a three-wire serial link made of an enable line, a shift clock and a data line. A frame begins with eight address bits, clocked in while the enable line is low. It continues with twenty-four payload bits, clocked in while the enable line is high. When the enable line drops again, the frame ends.

The address picks one of two 24-bit control images. The payload is copied into the chosen image only when three things hold: the address is one of the two known codes, at least eight address bits were seen, and exactly twenty-four payload bits arrived. Any other frame leaves both images as they were.

The three serial inputs are asynchronous to the core clock, so they pass through a synchronizer of configurable depth. Each rising shift-clock edge is detected in the core clock domain. Downstream logic reads the two raw images, a one-cycle write strobe for each image, and the decoded fields of the first image: a 16-bit divider value, two path-select bits, a counter-start bit and a 4-bit reference-select code.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset both images read all zeros, both strobes are low and every decoded field is zero.
- R2: Address bits are taken on rising shift-clock edges while enable is low, and the first bit sent becomes address bit 0. The sequence 0,0,0,1,0,1,0,0 in sending order (value 0x28) selects image A.
- R3: The sending order 1,0,0,1,0,1,0,0 (value 0x29) selects image B, and a write to B leaves A unchanged.
- R4: Payload bits are taken on rising shift-clock edges while enable is high. The first payload bit lands in bit 0 of the image and the 24th lands in bit 23.
- R5: A frame with 23 or with 25 payload bits leaves both images unchanged.
- R6: A frame whose address is neither 0x28 nor 0x29, including 0x14, leaves both images unchanged.
- R7: Each committed write raises exactly one strobe bit for one clock cycle: bit 0 for image A, bit 1 for image B. The strobe is high in the same cycle that the image first shows its new value.
- R8: Decoded fields of image A: divider value = bits 15:0, in_range_hi = bit 16, fm_path = bit 17, cnt_start = bit 18, ref_sel = bits 23:20. Bit 19 is not decoded.
- R9: With the default synchronizer depth of 2, the image and its strobe change at the third rising core-clock edge after the enable line falls.
- R10: A frame preceded by fewer than eight address bits since the previous enable fall leaves both images unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_ce | input | 1 | Serial enable: low for address, high for payload |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edges |
| ser_dat | input | 1 | Serial data |
| cfg_a | output | 24 | Image A contents |
| cfg_b | output | 24 | Image B contents |
| upd_stb | output | 2 | One-cycle write strobe per image |
| div_val | output | 16 | Divider value decoded from image A |
| in_range_hi | output | 1 | Input range select decoded from image A |
| fm_path | output | 1 | Divider path select decoded from image A |
| cnt_start | output | 1 | Counter start decoded from image A |
| ref_sel | output | 4 | Reference select code decoded from image A |

## Verification
Any fault in the address or payload shifter, or in the bit counters, only becomes visible when a frame closes. At that point it shows up within one clock cycle in one of three ways: an image takes a wrong value, an image fails to change, or a strobe fires for a frame that should have been rejected. A model in the bench predicts the images and strobes on every clock. Any deviation is therefore reported at the exact commit cycle, which is three core clocks after the enable falls. Off-by-one counting is exposed by frames that are one bit short, one bit long, or have a truncated address.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int ADDR_W = 8;
  localparam int PAY_W  = 24;
  localparam logic [ADDR_W-1:0] ADDR_IMG_A = 8'h28;
  localparam logic [ADDR_W-1:0] ADDR_IMG_B = 8'h29;

  typedef struct packed {
    logic [3:0]  ref_sel;
    logic        spare;
    logic        cnt_start;
    logic        fm_path;
    logic        in_range_hi;
    logic [15:0] div_val;
  } img_a_t;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = g_stage[g-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= src;
    end
  end

  assign dout = g_stage[STAGES-1].q;
endmodule

// File: rtl/ser_frame.sv
module ser_frame #(
  parameter int                ADDR_W = 8,
  parameter int                PAY_W  = 24,
  parameter logic [ADDR_W-1:0] ADDR_A = 8'h28,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'h29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             sck,
  input  logic             sd,
  output logic             wr_req,
  output logic             wr_sel,
  output logic [PAY_W-1:0] wr_data
);
  localparam int ACW = $clog2(ADDR_W + 1);
  localparam int PCW = $clog2(PAY_W + 2);
  localparam logic [ACW-1:0] ACNT_FULL = ACW'(ADDR_W);
  localparam logic [PCW-1:0] PCNT_OK   = PCW'(PAY_W);
  localparam logic [PCW-1:0] PCNT_OVER = PCW'(PAY_W + 1);

  logic              sck_q, ce_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ACW-1:0]    acnt_q, acnt_d;
  logic              hit_q, hit_d, sel_q, sel_d;
  logic [PCW-1:0]    pcnt_q, pcnt_d;
  logic [PAY_W-1:0]  pay_q, pay_d;
  logic              sck_rise, ce_rise, ce_fall;
  logic              addr_en, pay_en;

  assign sck_rise = sck & ~sck_q;
  assign ce_rise  = ce & ~ce_q;
  assign ce_fall  = ~ce & ce_q;
  assign addr_en  = sck_rise & ~ce;
  assign pay_en   = sck_rise & ce;

  always_comb begin
    addr_d = addr_q;
    acnt_d = acnt_q;
    hit_d  = hit_q;
    sel_d  = sel_q;
    pcnt_d = pcnt_q;
    pay_d  = pay_q;
    if (ce_fall) acnt_d = '0;
    if (ce_rise) begin
      hit_d  = (acnt_q == ACNT_FULL) && ((addr_q == ADDR_A) || (addr_q == ADDR_B));
      sel_d  = (addr_q == ADDR_B);
      pcnt_d = '0;
    end
    if (addr_en) begin
      addr_d = {sd, addr_q[ADDR_W-1:1]};
      if (acnt_q != ACNT_FULL) acnt_d = acnt_q + ACW'(1);
    end
    if (pay_en) begin
      pay_d = {sd, pay_q[PAY_W-1:1]};
      if (pcnt_q != PCNT_OVER) pcnt_d = pcnt_q + PCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      ce_q   <= 1'b0;
      addr_q <= '0;
      acnt_q <= '0;
      hit_q  <= 1'b0;
      sel_q  <= 1'b0;
      pcnt_q <= '0;
      pay_q  <= '0;
    end else begin
      sck_q  <= sck;
      ce_q   <= ce;
      addr_q <= addr_d;
      acnt_q <= acnt_d;
      hit_q  <= hit_d;
      sel_q  <= sel_d;
      pcnt_q <= pcnt_d;
      pay_q  <= pay_d;
    end
  end

  assign wr_req  = ce_fall & hit_q & (pcnt_q == PCNT_OK);
  assign wr_sel  = sel_q;
  assign wr_data = pay_q;

  // R2: the address shifter holds while the payload phase is active
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> $stable(addr_q));
  // R4: the payload shifter holds while the address phase is active
  p_pay_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(pay_q));
  // R5: the payload counter saturates one above a full frame
  p_pcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PCNT_OVER);
  // R10: the address counter never passes the address width
  p_acnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acnt_q <= ACNT_FULL);
endmodule

// File: rtl/ser_regbank.sv
module ser_regbank #(
  parameter int NREG = 2,
  parameter int W    = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_req,
  input  logic [$clog2(NREG)-1:0]  wr_sel,
  input  logic [W-1:0]             wr_data,
  output logic [NREG-1:0][W-1:0]   img,
  output logic [NREG-1:0]          stb
);
  for (genvar i = 0; i < NREG; i++) begin : g_img
    logic         we;
    logic [W-1:0] q_d;
    assign we  = wr_req && (wr_sel == i);
    assign q_d = we ? wr_data : img[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        img[i] <= '0;
        stb[i] <= 1'b0;
      end else begin
        img[i] <= q_d;
        stb[i] <= we;
      end
    end

    // R6: an image only moves in a cycle that carries its strobe
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !stb[i] |-> $stable(img[i]));
    // R7: a strobe lasts a single cycle
    p_stb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stb[i] |=> !stb[i]);
  end

  // R7: never more than one image written at once
  p_stb_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_ce,
  input  logic        ser_clk,
  input  logic        ser_dat,
  output logic [23:0] cfg_a,
  output logic [23:0] cfg_b,
  output logic [1:0]  upd_stb,
  output logic [15:0] div_val,
  output logic        in_range_hi,
  output logic        fm_path,
  output logic        cnt_start,
  output logic [3:0]  ref_sel
);
  import ser_ctl_pkg::*;

  localparam int NREG = 2;

  logic [1:0]           rst_pipe;
  logic                 rst_core_n;
  logic [2:0]           ser_s;
  logic                 wr_req, wr_sel;
  logic [PAY_W-1:0]     wr_data;
  logic [NREG-1:0][PAY_W-1:0] img;
  img_a_t               fa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  ser_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .din  ({ser_ce, ser_clk, ser_dat}),
    .dout (ser_s)
  );

  ser_frame #(
    .ADDR_W(ADDR_W), .PAY_W(PAY_W), .ADDR_A(ADDR_IMG_A), .ADDR_B(ADDR_IMG_B)
  ) u_frame (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .ce     (ser_s[2]),
    .sck    (ser_s[1]),
    .sd     (ser_s[0]),
    .wr_req (wr_req),
    .wr_sel (wr_sel),
    .wr_data(wr_data)
  );

  ser_regbank #(.NREG(NREG), .W(PAY_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_req (wr_req),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .img    (img),
    .stb    (upd_stb)
  );

  assign cfg_a       = img[0];
  assign cfg_b       = img[1];
  assign fa          = img_a_t'(img[0]);
  assign div_val     = fa.div_val;
  assign in_range_hi = fa.in_range_hi;
  assign fm_path     = fa.fm_path;
  assign cnt_start   = fa.cnt_start;
  assign ref_sel     = fa.ref_sel;
endmodule

// File: tb/ser_ctl_port_tb_top.sv
module ser_ctl_port_tb_top;
  localparam int SYNC = 2;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_ce = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [23:0] cfg_a, cfg_b;
  logic [1:0]  upd_stb;
  logic [15:0] div_val;
  logic        in_range_hi, fm_path, cnt_start;
  logic [3:0]  ref_sel;

  int n_chk = 0, n_bad = 0;
  int pulses_a = 0, pulses_b = 0;

  always #5 clk = ~clk;

  ser_ctl_port #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .upd_stb(upd_stb), .div_val(div_val),
    .in_range_hi(in_range_hi), .fm_path(fm_path), .cnt_start(cnt_start), .ref_sel(ref_sel)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: delayed input view, frame bookkeeping in integers
  logic [2:0]  hq[$];
  logic [23:0] e_a, e_b, m_pay;
  logic [7:0]  m_addr;
  logic [1:0]  e_stb;
  int          m_acnt, m_pcnt, m_sel;
  bit          m_hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq = '{3'b000, 3'b000, 3'b000};
      e_a = '0; e_b = '0; m_pay = '0; m_addr = '0; e_stb = '0;
      m_acnt = 0; m_pcnt = 0; m_sel = 0; m_hit = 0;
    end else begin
      logic [2:0] s, p;
      s = hq[SYNC-1];
      p = hq[SYNC];
      e_stb = '0;
      if (p[2] && !s[2]) begin
        if (m_hit && m_pcnt == 24) begin
          if (m_sel == 0) e_a = m_pay; else e_b = m_pay;
          e_stb[m_sel] = 1'b1;
        end
        m_acnt = 0;
      end
      if (s[2] && !p[2]) begin
        m_hit  = (m_acnt == 8) && (m_addr == 8'h28 || m_addr == 8'h29);
        m_sel  = (m_addr == 8'h29) ? 1 : 0;
        m_pcnt = 0;
      end
      if (s[1] && !p[1]) begin
        if (!s[2]) begin
          m_addr = {s[0], m_addr[7:1]};
          if (m_acnt < 8) m_acnt++;
        end else begin
          m_pay = {s[0], m_pay[23:1]};
          if (m_pcnt < 25) m_pcnt++;
        end
      end
      hq.push_front({ser_ce, ser_clk, ser_dat});
      void'(hq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2,R4 per-cycle cfg_a", {8'h0, cfg_a}, {8'h0, e_a});
      chk("R3,R4 per-cycle cfg_b", {8'h0, cfg_b}, {8'h0, e_b});
      chk("R7,R9 per-cycle strobe", {30'h0, upd_stb}, {30'h0, e_stb});
      if (upd_stb[0]) pulses_a++;
      if (upd_stb[1]) pulses_b++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(logic b);
    ser_dat = b;
    tick(HALF);
    ser_clk = 1'b1;
    tick(HALF);
    ser_clk = 1'b0;
  endtask

  task automatic open_frame(logic [7:0] a, int na, logic [23:0] d, int nd);
    ser_ce = 1'b0;
    tick(HALF);
    for (int i = 0; i < na; i++) sbit(a[i]);
    tick(HALF);
    ser_ce = 1'b1;
    tick(HALF);
    for (int i = 0; i < nd; i++) sbit(i < 24 ? d[i] : 1'b1);
    tick(HALF);
  endtask

  task automatic frame(logic [7:0] a, int na, logic [23:0] d, int nd);
    open_frame(a, na, d, nd);
    ser_ce = 1'b0;
    tick(8);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int pa0;
    tick(4);
    rst_n = 1'b1;
    tick(6);
    // R1
    chk("R1 cfg_a reset", {8'h0, cfg_a}, 32'h0);
    chk("R1 cfg_b reset", {8'h0, cfg_b}, 32'h0);
    chk("R1 strobe reset", {30'h0, upd_stb}, 32'h0);
    chk("R1 fields reset", {div_val, in_range_hi, fm_path, cnt_start, ref_sel}, 32'h0);

    // R2 + R8
    pa0 = pulses_a;
    frame(8'h28, 8, 24'hB5C3A7, 24);
    chk("R2 write image A", {8'h0, cfg_a}, 32'h00B5C3A7);
    chk("R8 div_val", {16'h0, div_val}, 32'h0000C3A7);
    chk("R8 in_range_hi", {31'h0, in_range_hi}, 32'h1);
    chk("R8 fm_path", {31'h0, fm_path}, 32'h0);
    chk("R8 cnt_start", {31'h0, cnt_start}, 32'h1);
    chk("R8 ref_sel", {28'h0, ref_sel}, 32'hB);
    chk("R7 one pulse for A", pulses_a - pa0, 32'd1);

    // R3
    frame(8'h29, 8, 24'h3C0F96, 24);
    chk("R3 write image B", {8'h0, cfg_b}, 32'h003C0F96);
    chk("R3 image A kept", {8'h0, cfg_a}, 32'h00B5C3A7);
    chk("R7 one pulse for B", pulses_b, 32'd1);

    // R4 bit order
    frame(8'h28, 8, 24'h000001, 24);
    chk("R4 first bit to bit0", {8'h0, cfg_a}, 32'h00000001);
    frame(8'h28, 8, 24'h800000, 24);
    chk("R4 last bit to bit23", {8'h0, cfg_a}, 32'h00800000);

    // R5 wrong payload length
    frame(8'h28, 8, 24'h123456, 23);
    chk("R5 23 bits ignored", {8'h0, cfg_a}, 32'h00800000);
    frame(8'h29, 8, 24'h654321, 25);
    chk("R5 25 bits ignored", {8'h0, cfg_b}, 32'h003C0F96);

    // R6 unknown address
    frame(8'h68, 8, 24'hFFFFFF, 24);
    chk("R6 addr 0x68 A kept", {8'h0, cfg_a}, 32'h00800000);
    chk("R6 addr 0x68 B kept", {8'h0, cfg_b}, 32'h003C0F96);
    frame(8'h14, 8, 24'hFFFFFF, 24);
    chk("R6 addr 0x14 A kept", {8'h0, cfg_a}, 32'h00800000);

    // R10 short address
    frame(8'h28, 5, 24'h0F0F0F, 24);
    chk("R10 short address ignored", {8'h0, cfg_a}, 32'h00800000);

    // R9 commit latency
    open_frame(8'h28, 8, 24'h5A5A5A, 24);
    ser_ce = 1'b0;
    tick(1);
    chk("R9 edge1 unchanged", {8'h0, cfg_a}, 32'h00800000);
    tick(1);
    chk("R9 edge2 unchanged", {8'h0, cfg_a}, 32'h00800000);
    tick(1);
    chk("R9 edge3 updated", {8'h0, cfg_a}, 32'h005A5A5A);
    chk("R7 strobe with data", {30'h0, upd_stb}, 32'h1);
    tick(1);
    chk("R7 strobe one cycle", {30'h0, upd_stb}, 32'h0);
    tick(8);

    summary();
    $finish;
  end
endmodule